// File: doc/BRIEF.md
# Integer ALU with Operand Bypass

A purely combinational integer arithmetic-logic unit for a small 32-bit scalar core. Two operands, a 3-bit operation code, one modifier bit and a bypass control come in; a result word and an equality flag go out, with no clock and no state. The operation code follows the usual base-integer function-field numbering. The single modifier bit does two jobs: it turns the add into a subtract, and it turns the logical right shift into an arithmetic one.

The bypass control makes the unit forward its second operand unchanged. This serves instructions that only need to move an immediate into a register. The equality flag compares the two operands on its own, whatever the operation code, modifier or bypass say, so branch logic can use it while the result word is busy with something else.

Operand width, the shifter structure and whether the compare shares the subtractor are parameters. Their defaults give a 32-bit unit.

Top module: `ialu_core`

## Requirements
- R1: With `pass`=0, `op_sel`=3'b000 and `alt`=0, `res` equals `op_a + op_b` modulo 2^32. There is no carry output.
- R2: With `pass`=0, `op_sel`=3'b000 and `alt`=1, `res` equals `op_a - op_b` modulo 2^32.
- R3: With `pass`=0 and `op_sel`=3'b001, `res` is `op_a` shifted left and zero-filled. The shift amount is `op_b[4:0]`, and `op_b[31:5]` is ignored.
- R4: With `pass`=0 and `op_sel`=3'b101, `res` is `op_a` shifted right by `op_b[4:0]`. The vacated bits are filled with zeros when `alt`=0 and with copies of `op_a[31]` when `alt`=1.
- R5: With `pass`=0 and `op_sel`=3'b010, `res` is 32'd1 when `op_a` is less than `op_b` as two's-complement numbers, otherwise 32'd0.
- R6: With `pass`=0 and `op_sel`=3'b011, `res` is 32'd1 when `op_a` is less than `op_b` as unsigned numbers, otherwise 32'd0.
- R7: With `pass`=0, `op_sel`=3'b100 gives `op_a ^ op_b`, 3'b110 gives `op_a | op_b` and 3'b111 gives `op_a & op_b`.
- R8: For `op_sel` values other than 3'b000 and 3'b101, `alt` has no effect on `res`.
- R9: With `pass`=1, `res` equals `op_b` for every `op_sel` and `alt`.
- R10: `eq` is 1 exactly when `op_a` equals `op_b`, whatever `op_sel`, `alt` and `pass` are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 32 | First operand; the value that is shifted |
| op_b | input | 32 | Second operand; its low 5 bits give the shift amount; it is the bypass value |
| op_sel | input | 3 | Operation code |
| alt | input | 1 | Modifier: subtract instead of add, arithmetic instead of logical right shift |
| pass | input | 1 | Bypass: forward `op_b` to `res` |
| res | output | 32 | Result word |
| eq | output | 1 | Operands-equal flag |

## Verification
The checker assumes that every input is at a known 0 or 1 level. It skips its checks while any input is unknown, and the bench drives every input from time zero. Because the unit has no state, each property relates outputs to inputs within one evaluation. The properties only need `op_sel` to be one of the eight defined codes; a 3-bit field cannot hold anything else. The stimulus uses fixed corner values (sign boundaries, carry wrap, shift amounts of 0 and 31, amounts whose upper bits are set) together with a pseudo-random sweep over every code, both modifier values and both bypass values.

// File: rtl/ialu_pkg.sv
package ialu_pkg;

   typedef enum logic [2:0] {
      OP_ADD  = 3'b000,
      OP_SHL  = 3'b001,
      OP_LTS  = 3'b010,
      OP_LTU  = 3'b011,
      OP_XOR  = 3'b100,
      OP_SHR  = 3'b101,
      OP_OR   = 3'b110,
      OP_AND  = 3'b111
   } op_e;

   function automatic bit is_pow2(int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/ialu_addsub.sv
module ialu_addsub #(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic             sub,
   output logic [WIDTH-1:0] sum,
   output logic             carry
);
   logic [WIDTH-1:0] b_eff;
   logic [WIDTH:0]   full;

   // subtract as a + ~b + 1 so one carry chain serves both
   assign b_eff = b ^ {WIDTH{sub}};
   assign full  = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, sub};
   assign sum   = full[WIDTH-1:0];
   assign carry = full[WIDTH];
endmodule

// File: rtl/ialu_shift.sv
module ialu_shift #(
   parameter int WIDTH  = 32,
   parameter bit BARREL = 1'b1,
   localparam int SHW   = $clog2(WIDTH)
) (
   input  logic [WIDTH-1:0] din,
   input  logic [SHW-1:0]   amt,
   input  logic             left,
   input  logic             arith,
   output logic [WIDTH-1:0] dout
);
   logic [WIDTH-1:0] rin;
   logic [WIDTH-1:0] rout;
   logic             fill;

   // a single right shifter serves both directions; left shifts go through bit reversal
   for (genvar g = 0; g < WIDTH; g++) begin : g_rev_in
      assign rin[g]  = left ? din[WIDTH-1-g] : din[g];
   end
   for (genvar g = 0; g < WIDTH; g++) begin : g_rev_out
      assign dout[g] = left ? rout[WIDTH-1-g] : rout[g];
   end

   assign fill = arith & ~left & din[WIDTH-1];

   if (BARREL) begin : g_barrel
      logic [WIDTH-1:0] st [0:SHW];
      assign st[0] = rin;
      for (genvar i = 0; i < SHW; i++) begin : g_stage
         localparam int K = 1 << i;
         assign st[i+1] = amt[i] ? {{K{fill}}, st[i][WIDTH-1:K]} : st[i];
      end
      assign rout = st[SHW];
   end else begin : g_plain
      logic signed [WIDTH:0] ext;
      logic signed [WIDTH:0] shd;
      assign ext  = {fill, rin};
      assign shd  = ext >>> amt;
      assign rout = shd[WIDTH-1:0];
   end
endmodule

// File: rtl/ialu_bitwise.sv
module ialu_bitwise #(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic [1:0]       fn,
   output logic [WIDTH-1:0] y
);
   always_comb begin
      unique case (fn)
         2'b00:   y = a ^ b;
         2'b10:   y = a | b;
         2'b11:   y = a & b;
         default: y = '0;
      endcase
   end
endmodule

// File: rtl/ialu_core.sv
module ialu_core #(
   parameter int WIDTH     = 32,
   parameter bit BARREL    = 1'b1,
   parameter bit SHARE_CMP = 1'b1,
   localparam int SHW      = $clog2(WIDTH)
) (
   input  logic [WIDTH-1:0] op_a,
   input  logic [WIDTH-1:0] op_b,
   input  logic [2:0]       op_sel,
   input  logic             alt,
   input  logic             pass,
   output logic [WIDTH-1:0] res,
   output logic             eq
);
   import ialu_pkg::*;

   if (WIDTH < 8 || !is_pow2(WIDTH)) begin : g_bad_width
      $error("ialu_core: WIDTH must be a power of two and at least 8");
   end

   op_e              op;
   logic             is_cmp;
   logic             sub;
   logic [WIDTH-1:0] sum;
   logic             carry;
   logic [WIDTH-1:0] shv;
   logic [WIDTH-1:0] bwv;
   logic             lt_s;
   logic             lt_u;

   assign op     = op_e'(op_sel);
   assign is_cmp = (op == OP_LTS) || (op == OP_LTU);

   if (SHARE_CMP) begin : g_cmp_shared
      // compares reuse the subtractor: no carry out of a - b means a < b unsigned
      assign sub  = (alt & (op == OP_ADD)) | is_cmp;
      assign lt_u = ~carry;
      assign lt_s = (op_a[WIDTH-1] ^ op_b[WIDTH-1]) ? op_a[WIDTH-1] : ~carry;
   end else begin : g_cmp_own
      assign sub  = alt & (op == OP_ADD);
      assign lt_u = op_a < op_b;
      assign lt_s = $signed(op_a) < $signed(op_b);
   end

   ialu_addsub #(.WIDTH(WIDTH)) addsub_i (
      .a     (op_a),
      .b     (op_b),
      .sub   (sub),
      .sum   (sum),
      .carry (carry)
   );

   ialu_shift #(.WIDTH(WIDTH), .BARREL(BARREL)) shift_i (
      .din   (op_a),
      .amt   (op_b[SHW-1:0]),
      .left  (op == OP_SHL),
      .arith (alt),
      .dout  (shv)
   );

   ialu_bitwise #(.WIDTH(WIDTH)) bitwise_i (
      .a  (op_a),
      .b  (op_b),
      .fn (op_sel[1:0]),
      .y  (bwv)
   );

   assign eq = ~|(op_a ^ op_b);

   always_comb begin
      res = '0;
      if (pass) begin
         res = op_b;
      end else begin
         unique case (op)
            OP_ADD:                 res = sum;
            OP_SHL, OP_SHR:         res = shv;
            OP_LTS:                 res = {{(WIDTH-1){1'b0}}, lt_s};
            OP_LTU:                 res = {{(WIDTH-1){1'b0}}, lt_u};
            OP_XOR, OP_OR, OP_AND:  res = bwv;
            default:                res = '0;
         endcase
      end
   end
endmodule

// File: rtl/ialu_core_chk.sv
module ialu_core_chk #(
   parameter int WIDTH = 32,
   localparam int SHW  = $clog2(WIDTH)
) (
   input logic [WIDTH-1:0] op_a,
   input logic [WIDTH-1:0] op_b,
   input logic [2:0]       op_sel,
   input logic             alt,
   input logic             pass,
   input logic [WIDTH-1:0] res,
   input logic             eq
);
   always_comb begin
      if (!$isunknown({op_a, op_b, op_sel, alt, pass})) begin
         AST_EQ_INDEP: assert (eq == (op_a == op_b)) else $error("eq flag mismatch"); // R10
         if (pass) begin
            AST_BYPASS_FWD: assert (res == op_b) else $error("bypass not forwarded"); // R9
         end else begin
            if (op_sel == 3'b000 && !alt) begin
               AST_ADD_INV: assert (WIDTH'(res - op_b) == op_a) else $error("add wrong"); // R1
            end
            if (op_sel == 3'b000 && alt) begin
               AST_SUB_INV: assert (WIDTH'(res + op_b) == op_a) else $error("sub wrong"); // R2
            end
            if (op_sel == 3'b001 && op_b[SHW-1:0] == '0) begin
               AST_SHL_ZERO: assert (res == op_a) else $error("zero shift changed value"); // R3
            end
            if (op_sel == 3'b101 && alt) begin
               AST_SRA_SIGN: assert (res[WIDTH-1] == op_a[WIDTH-1]) else $error("sign lost"); // R4
            end
            if (op_sel == 3'b010 || op_sel == 3'b011) begin
               AST_CMP_BOOL: assert (res[WIDTH-1:1] == '0) else $error("compare not 0/1"); // R5
            end
            if (op_sel == 3'b011 && op_a == op_b) begin
               AST_LTU_EQ: assert (res == '0) else $error("equal operands less"); // R6
            end
            if (op_sel == 3'b111) begin
               AST_AND_SUB: assert ((res & ~op_a) == '0) else $error("and sets bits"); // R7
            end
         end
      end
   end
endmodule

bind ialu_core ialu_core_chk #(.WIDTH(WIDTH)) chk_i (
   .op_a   (op_a),
   .op_b   (op_b),
   .op_sel (op_sel),
   .alt    (alt),
   .pass   (pass),
   .res    (res),
   .eq     (eq)
);

// File: tb/ialu_core_tb_top.sv
`timescale 1ns/1ps
module ialu_core_tb_top;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] op_a = '0;
   logic [31:0] op_b = '0;
   logic [2:0]  op_sel = '0;
   logic        alt = 1'b0;
   logic        pass = 1'b0;
   logic [31:0] res;
   logic        eq;
   int          n_chk = 0;
   int          n_fail = 0;
   int          cyc = 0;
   logic [31:0] lfsr = 32'h1ACE_B00C;

   ialu_core dut_i (
      .op_a (op_a), .op_b (op_b), .op_sel (op_sel), .alt (alt), .pass (pass),
      .res (res), .eq (eq)
   );

   always #2 clk = ~clk;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 100000) begin
         n_fail = n_fail + 1;
         $display("FAIL watchdog got=%0d exp=<100000", cyc);
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   function automatic logic [31:0] model(logic [31:0] a, logic [31:0] b,
                                         logic [2:0] s, logic m, logic p);
      logic [4:0] sh = b[4:0];
      if (p) return b;
      case (s)
         3'b000: return m ? a - b : a + b;
         3'b001: return a << sh;
         3'b010: return {31'd0, $signed(a) < $signed(b)};
         3'b011: return {31'd0, a < b};
         3'b100: return a ^ b;
         3'b101: return m ? 32'($signed(a) >>> sh) : a >> sh;
         3'b110: return a | b;
         default: return a & b;
      endcase
   endfunction

   task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s got=%h exp=%h", tag, got, exp);
      end
   endtask

   task automatic apply(logic [31:0] a, logic [31:0] b, logic [2:0] s, logic m, logic p);
      @(negedge clk);
      op_a = a; op_b = b; op_sel = s; alt = m; pass = p;
      #1;
   endtask

   task automatic run(string tag, logic [31:0] a, logic [31:0] b, logic [2:0] s, logic m,
                      logic p, logic [31:0] exp);
      apply(a, b, s, m, p);
      check(tag, res, exp);
   endtask

   task automatic t_idle();
      apply('0, '0, 3'b000, 1'b0, 1'b0);
      check("R1 idle res", res, 32'd0);
      check("R10 idle eq", {31'd0, eq}, 32'd1);
   endtask

   task automatic t_addsub();
      run("R1 add", 32'hDEAD_BEEF, 32'h1, 3'b000, 0, 0, 32'hDEAD_BEF0);
      run("R1 wrap", 32'hFFFF_FFFF, 32'h1, 3'b000, 0, 0, 32'h0);
      run("R2 sub", 32'h10, 32'h3, 3'b000, 1, 0, 32'hD);
      run("R2 wrap", 32'h0, 32'h1, 3'b000, 1, 0, 32'hFFFF_FFFF);
   endtask

   task automatic t_shift();
      run("R3 shl", 32'h1, 32'd31, 3'b001, 0, 0, 32'h8000_0000);
      run("R3 upper ignored", 32'h3, 32'hFFFF_FFE1, 3'b001, 0, 0, 32'h6);
      run("R3 zero amt", 32'h1234_5678, 32'h20, 3'b001, 0, 0, 32'h1234_5678);
      run("R4 srl", 32'h8000_0000, 32'd4, 3'b101, 0, 0, 32'h0800_0000);
      run("R4 sra", 32'h8000_0000, 32'd4, 3'b101, 1, 0, 32'hF800_0000);
      run("R4 sra pos", 32'h4000_0000, 32'd31, 3'b101, 1, 0, 32'h0);
      run("R4 sra 31", 32'hDEAD_BEEF, 32'hFFFF_FFFF, 3'b101, 1, 0, 32'hFFFF_FFFF);
   endtask

   task automatic t_cmp();
      run("R5 neg<pos", 32'hFFFF_FFFF, 32'h1, 3'b010, 0, 0, 32'h1);
      run("R5 pos<neg", 32'h1, 32'h8000_0000, 3'b010, 0, 0, 32'h0);
      run("R5 equal", 32'h7, 32'h7, 3'b010, 0, 0, 32'h0);
      run("R6 big<small", 32'hFFFF_FFFF, 32'h1, 3'b011, 0, 0, 32'h0);
      run("R6 small<big", 32'h1, 32'h8000_0000, 3'b011, 0, 0, 32'h1);
      run("R6 equal", 32'h8000_0000, 32'h8000_0000, 3'b011, 0, 0, 32'h0);
   endtask

   task automatic t_logic();
      run("R7 xor", 32'hF0F0_00FF, 32'hFF00_0F0F, 3'b100, 0, 0, 32'h0FF0_0FF0);
      run("R7 or",  32'hF0F0_00FF, 32'hFF00_0F0F, 3'b110, 0, 0, 32'hFFF0_0FFF);
      run("R7 and", 32'hF0F0_00FF, 32'hFF00_0F0F, 3'b111, 0, 0, 32'hF000_000F);
   endtask

   task automatic t_alt_ignored();
      logic [31:0] a = 32'h8123_4567;
      logic [31:0] b = 32'hFEDC_BA95;
      for (int s = 0; s < 8; s++) begin
         if (s == 0 || s == 5) continue;
         run("R8 alt ignored", a, b, 3'(s), 1'b1, 1'b0, model(a, b, 3'(s), 1'b0, 1'b0));
      end
   endtask

   task automatic t_bypass();
      for (int s = 0; s < 8; s++) begin
         run("R9 bypass", 32'h1111_2222, 32'hABCD_E000 + 32'(s), 3'(s), s[0], 1'b1,
             32'hABCD_E000 + 32'(s));
      end
   endtask

   task automatic t_eq();
      apply(32'h5A5A_5A5A, 32'h5A5A_5A5A, 3'b100, 1, 1);
      check("R10 eq bypass", {31'd0, eq}, 32'd1);
      apply(32'h5A5A_5A5A, 32'h5A5A_5A5B, 3'b000, 1, 0);
      check("R10 ne lsb", {31'd0, eq}, 32'd0);
      apply(32'h0000_0001, 32'h8000_0001, 3'b111, 0, 0);
      check("R10 ne msb", {31'd0, eq}, 32'd0);
   endtask

   task automatic t_sweep();
      for (int i = 0; i < 400; i++) begin
         logic [31:0] a;
         logic [31:0] b;
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         a = lfsr ^ (lfsr << 7);
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         b = (i % 5 == 0) ? a : lfsr * 32'h9E37_79B9;
         apply(a, b, 3'(i), i[3], (i % 11) == 0);
         check("R1 R9 sweep res", res, model(a, b, 3'(i), i[3], (i % 11) == 0));
         check("R10 sweep eq", {31'd0, eq}, {31'd0, a == b});
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      rst = 1'b0;
      t_idle();
      t_addsub();
      t_shift();
      t_cmp();
      t_logic();
      t_alt_ignored();
      t_bypass();
      t_eq();
      t_sweep();
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule